// File: doc/BRIEF.md
# Three-Client Programmable-Priority Burst Arbiter

This block lets three 32-bit clients share one buffer-memory command port: a host-side FIFO, a disc-side FIFO and a processor instruction fetch. Each client raises a request and presents a direction and a byte address. The winner is picked from a priority order that software can change at any time. The winner then owns the port for a burst of up to eight beats, which is 32 bytes. Arbitration is combinational. A requester that finds the port free can transfer its first beat in the same cycle. A new owner can start in the cycle after a burst ends.

The memory side has a command valid, a write flag, an address, write data and an owner tag. Handshaking uses a single ready input, and one beat transfers on every cycle where a command is valid and ready is high. Read data comes back with the tag that was issued with the command. The block steers the valid strobe to the matching client and shares the data bus among all clients. A client learns that a beat was taken from its grant strobe. That strobe is high only in cycles where that client's beat moves, so the client advances its address and data on each strobe.

Top module: `burst_port_arbiter`

## Requirements
- R1: After reset no client owns the port. With no requests pending, all grants and the command valid are low.
- R2: The priority input holds three 2-bit client numbers. Bits [1:0] name the most favoured client, bits [3:2] the next and bits [5:4] the least. A free port goes to the best-ranked requester in the same cycle.
- R3: A priority setting that repeats a client number or uses the value 3 is treated as the order client 0, then client 1, then client 2.
- R4: Once its first beat transfers, a client keeps the port until eight beats have transferred, even if a better-ranked request appears or the priority changes.
- R5: At most one grant is high at a time. A grant is high only when its client requests and ready is high. The command valid is high whenever any client holds or could win the port.
- R6: While ready is low, no beat transfers. The owner and its beat count are kept while the owner still requests.
- R7: The first beat carries the client's address. Each later beat of the burst carries the previous beat's address plus 4. The write flag is taken from the first beat and held for the rest of the burst. Write data comes from the owner every beat.
- R8: If the owner drops its request, its burst ends. In that same cycle another requester may win and transfer a beat.
- R9: In the cycle after a burst's eighth beat, the port is arbitrated afresh. A waiting client can transfer its first beat in that cycle.
- R10: A returned read with tag 0, 1 or 2 raises only that client's data-valid strobe. Tag 3 raises none. The read data bus is shared by all clients.
- R11: The command's tag output is the number of the client whose command is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| prioOrder | input | 6 | Priority ranking, three 2-bit client numbers |
| clientReq | input | 3 | Request per client |
| clientWe | input | 3 | Write direction per client |
| clientAddr | input | 96 | Byte address per client, client i at bits [32i+31:32i] |
| clientWdata | input | 96 | Write data per client, same packing |
| clientGnt | output | 3 | Beat transferred for the client this cycle |
| clientRvalid | output | 3 | Read data valid per client |
| clientRdata | output | 32 | Shared read data |
| memCmdValid | output | 1 | Command valid toward memory |
| memCmdWe | output | 1 | Command is a write |
| memCmdAddr | output | 32 | Command byte address |
| memCmdId | output | 2 | Owner tag of the command |
| memWdata | output | 32 | Write data |
| memReady | input | 1 | Memory accepts the command this cycle |
| memRvalid | input | 1 | Read data valid from memory |
| memRid | input | 2 | Tag of the returned read |
| memRdata | input | 32 | Read data from memory |

## Verification
The embedded properties check these rules on every cycle: grants are one-hot and backed by a request and ready, a burst stays locked after its first beat, owner and count are frozen while ready is low, addresses step by four within a burst, the write flag is held, and returned read strobes are routed correctly. Only the bench scenarios can show the rest. These are ranking by each priority setting including the illegal ones, the exact eight-beat length and the same-cycle handover after it, handover on an early drop, and the match of address and data with a client-side expectation under random request and ready patterns.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_CLIENTS = 3;
  localparam int ID_W        = 2;

  typedef logic [ID_W-1:0] clientId_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      selValid;   // some client is shown on the port
    clientId_t selId;      // which client
    logic      continuing; // shown client is an owner mid-burst
    logic      beatFire;   // a beat transfers this cycle
  } ctrlStrobes_t;
endpackage

// File: rtl/arb_prio_decode.sv
module arb_prio_decode
  import arb_pkg::*;
(
  input  logic [NUM_CLIENTS*ID_W-1:0] prioOrder,
  output logic [NUM_CLIENTS*ID_W-1:0] orderOut
);
  localparam int MASK_W = 1 << ID_W;

  logic [MASK_W-1:0] seenMask;
  logic              permOk;
  logic [NUM_CLIENTS*ID_W-1:0] fallbackOrder;

  genvar g;
  generate
    for (g = 0; g < NUM_CLIENTS; g++) begin : gFallback
      assign fallbackOrder[g*ID_W +: ID_W] = ID_W'(g);
    end
  endgenerate

  always_comb begin
    seenMask = '0;
    for (int r = 0; r < NUM_CLIENTS; r++) begin
      seenMask[prioOrder[r*ID_W +: ID_W]] = 1'b1;
    end
    permOk = 1'b1;
    for (int c = 0; c < MASK_W; c++) begin
      if ((c < NUM_CLIENTS) != seenMask[c]) permOk = 1'b0;
    end
  end

  assign orderOut = permOk ? prioOrder : fallbackOrder;
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int BURST_LEN = 8
)(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CLIENTS*ID_W-1:0] orderIn,
  input  logic [NUM_CLIENTS-1:0]      clientReq,
  input  logic                        memReady,
  output ctrlStrobes_t                strobes,
  output logic [NUM_CLIENTS-1:0]      clientGnt
);
  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BURST_LEN - 1);

  logic             locked;
  clientId_t        ownerId;
  logic [CNT_W-1:0] beatCnt;

  logic      winValid;
  clientId_t winId;
  logic      ownerReq;
  logic      continuing;
  logic      selValid;
  clientId_t selId;
  logic      beatFire;

  // zero-cycle winner pick: scan from lowest rank so best rank is assigned last
  always_comb begin
    winValid = 1'b0;
    winId    = '0;
    for (int r = NUM_CLIENTS - 1; r >= 0; r--) begin
      if (32'(orderIn[r*ID_W +: ID_W]) < NUM_CLIENTS && clientReq[orderIn[r*ID_W +: ID_W]]) begin
        winValid = 1'b1;
        winId    = orderIn[r*ID_W +: ID_W];
      end
    end
  end

  always_comb begin
    ownerReq = 1'b0;
    for (int c = 0; c < NUM_CLIENTS; c++) begin
      if (ownerId == ID_W'(c)) ownerReq = clientReq[c];
    end
  end

  assign continuing = locked && ownerReq;
  assign selValid   = continuing || winValid;
  assign selId      = continuing ? ownerId : winId;
  assign beatFire   = selValid && memReady;

  assign strobes.selValid   = selValid;
  assign strobes.selId      = selId;
  assign strobes.continuing = continuing;
  assign strobes.beatFire   = beatFire;

  genvar g;
  generate
    for (g = 0; g < NUM_CLIENTS; g++) begin : gGrant
      assign clientGnt[g] = beatFire && (selId == ID_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked  <= 1'b0;
      ownerId <= '0;
      beatCnt <= '0;
    end else if (continuing) begin
      if (beatFire) begin
        if (beatCnt == LAST_CNT) begin
          locked  <= 1'b0;
          beatCnt <= '0;
        end else begin
          beatCnt <= beatCnt + CNT_W'(1);
        end
      end
    end else if (beatFire) begin
      locked  <= (BURST_LEN > 1);
      ownerId <= winId;
      beatCnt <= (BURST_LEN > 1) ? CNT_W'(1) : '0;
    end else begin
      locked  <= 1'b0;
      beatCnt <= '0;
    end
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clientGnt));

  // R5
  gnt_backed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|clientGnt) |-> (memReady && (|(clientGnt & clientReq))));

  // R4
  burst_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatFire && !continuing) |=> (locked && ownerId == $past(winId)));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (continuing && !memReady) |=> (locked && $stable(ownerId) && $stable(beatCnt)));
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
)(
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strobes,
  input  logic [NUM_CLIENTS-1:0]        clientWe,
  input  logic [NUM_CLIENTS*ADDR_W-1:0] clientAddr,
  input  logic [NUM_CLIENTS*DATA_W-1:0] clientWdata,
  input  logic                          memRvalid,
  input  logic [ID_W-1:0]               memRid,
  input  logic [DATA_W-1:0]             memRdata,
  output logic                          memCmdValid,
  output logic                          memCmdWe,
  output logic [ADDR_W-1:0]             memCmdAddr,
  output logic [ID_W-1:0]               memCmdId,
  output logic [DATA_W-1:0]             memWdata,
  output logic [NUM_CLIENTS-1:0]        clientRvalid,
  output logic [DATA_W-1:0]             clientRdata
);
  localparam logic [ADDR_W-1:0] BEAT_BYTES = ADDR_W'(DATA_W / 8);

  logic [ADDR_W-1:0] addrArr  [NUM_CLIENTS];
  logic [DATA_W-1:0] wdataArr [NUM_CLIENTS];

  logic [ADDR_W-1:0] addrReg;
  logic              weReg;
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selWdata;
  logic              selWe;

  genvar g;
  generate
    for (g = 0; g < NUM_CLIENTS; g++) begin : gUnpack
      assign addrArr[g]  = clientAddr[g*ADDR_W +: ADDR_W];
      assign wdataArr[g] = clientWdata[g*DATA_W +: DATA_W];
      assign clientRvalid[g] = memRvalid && (memRid == ID_W'(g));
    end
  endgenerate

  always_comb begin
    selAddr  = '0;
    selWdata = '0;
    selWe    = 1'b0;
    for (int c = 0; c < NUM_CLIENTS; c++) begin
      if (strobes.selId == ID_W'(c)) begin
        selAddr  = addrArr[c];
        selWdata = wdataArr[c];
        selWe    = clientWe[c];
      end
    end
  end

  assign memCmdValid = strobes.selValid;
  assign memCmdId    = strobes.selId;
  assign memCmdAddr  = strobes.continuing ? addrReg : selAddr;
  assign memCmdWe    = strobes.continuing ? weReg : selWe;
  assign memWdata    = selWdata;
  assign clientRdata = memRdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      weReg   <= 1'b0;
    end else if (strobes.beatFire) begin
      addrReg <= memCmdAddr + BEAT_BYTES;
      weReg   <= memCmdWe;
    end
  end

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.beatFire |=> (!strobes.continuing || memCmdAddr == $past(memCmdAddr) + BEAT_BYTES));

  // R7
  we_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.beatFire |=> (!strobes.continuing || memCmdWe == $past(memCmdWe)));

  // R10
  rvalid_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|clientRvalid) |-> (memRvalid && $onehot(clientRvalid)));
endmodule

// File: rtl/burst_port_arbiter.sv
module burst_port_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 8
)(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CLIENTS*ID_W-1:0]   prioOrder,
  input  logic [NUM_CLIENTS-1:0]        clientReq,
  input  logic [NUM_CLIENTS-1:0]        clientWe,
  input  logic [NUM_CLIENTS*ADDR_W-1:0] clientAddr,
  input  logic [NUM_CLIENTS*DATA_W-1:0] clientWdata,
  output logic [NUM_CLIENTS-1:0]        clientGnt,
  output logic [NUM_CLIENTS-1:0]        clientRvalid,
  output logic [DATA_W-1:0]             clientRdata,
  output logic                          memCmdValid,
  output logic                          memCmdWe,
  output logic [ADDR_W-1:0]             memCmdAddr,
  output logic [ID_W-1:0]               memCmdId,
  output logic [DATA_W-1:0]             memWdata,
  input  logic                          memReady,
  input  logic                          memRvalid,
  input  logic [ID_W-1:0]               memRid,
  input  logic [DATA_W-1:0]             memRdata
);
  logic [NUM_CLIENTS*ID_W-1:0] orderEff;
  ctrlStrobes_t                strobes;

  arb_prio_decode prio_i (
    .prioOrder (prioOrder),
    .orderOut  (orderEff)
  );

  arb_ctrl #(.BURST_LEN(BURST_LEN)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .orderIn   (orderEff),
    .clientReq (clientReq),
    .memReady  (memReady),
    .strobes   (strobes),
    .clientGnt (clientGnt)
  );

  arb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .clientWe     (clientWe),
    .clientAddr   (clientAddr),
    .clientWdata  (clientWdata),
    .memRvalid    (memRvalid),
    .memRid       (memRid),
    .memRdata     (memRdata),
    .memCmdValid  (memCmdValid),
    .memCmdWe     (memCmdWe),
    .memCmdAddr   (memCmdAddr),
    .memCmdId     (memCmdId),
    .memWdata     (memWdata),
    .clientRvalid (clientRvalid),
    .clientRdata  (clientRdata)
  );
endmodule

// File: tb/burst_port_arbiter_tb.sv
module burst_port_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  prioOrder;
  logic [2:0]  clientReq;
  logic [2:0]  clientWe;
  logic [95:0] clientAddr;
  logic [95:0] clientWdata;
  logic        memReady;
  logic        memRvalid;
  logic [1:0]  memRid;
  logic [31:0] memRdata;
  logic [2:0]  clientGnt;
  logic [2:0]  clientRvalid;
  logic [31:0] clientRdata;
  logic        memCmdValid;
  logic        memCmdWe;
  logic [31:0] memCmdAddr;
  logic [1:0]  memCmdId;
  logic [31:0] memWdata;

  always #5 clk = ~clk;

  burst_port_arbiter dut_i (
    .clk(clk), .rstN(rstN), .prioOrder(prioOrder), .clientReq(clientReq),
    .clientWe(clientWe), .clientAddr(clientAddr), .clientWdata(clientWdata),
    .clientGnt(clientGnt), .clientRvalid(clientRvalid), .clientRdata(clientRdata),
    .memCmdValid(memCmdValid), .memCmdWe(memCmdWe), .memCmdAddr(memCmdAddr),
    .memCmdId(memCmdId), .memWdata(memWdata), .memReady(memReady),
    .memRvalid(memRvalid), .memRid(memRid), .memRdata(memRdata)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  // client-side expectation state
  bit          mLocked = 0;
  int          mOwner  = 0;
  int          mCnt    = 0;
  logic [31:0] mAddr   = '0;
  logic        mWe     = 1'b0;

  localparam logic [5:0] DISC_FIRST = {2'd2, 2'd0, 2'd1};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // R2/R3: legal ranking or the default 0,1,2
  function automatic logic [5:0] effOrder(input logic [5:0] p);
    logic [3:0] seen = '0;
    for (int r = 0; r < 3; r++) seen[p[r*2 +: 2]] = 1'b1;
    return (seen == 4'b0111) ? p : {2'd2, 2'd1, 2'd0};
  endfunction

  // compares one cycle, then advances the expectation; ends on the next falling edge
  task automatic step(input string tag, input int expGnt = -1);
    logic [5:0]  ord;
    bit          cont;
    int          sel;
    bit          fire;
    logic [2:0]  eGnt;
    logic [31:0] eAddr;
    logic        eWe;
    logic [2:0]  eRv;
    #1;
    ord  = effOrder(prioOrder);
    cont = mLocked && clientReq[mOwner];
    sel  = -1;
    if (cont) sel = mOwner;
    else begin
      for (int r = 0; r < 3; r++)
        if (sel < 0 && clientReq[ord[r*2 +: 2]]) sel = int'(ord[r*2 +: 2]);
    end
    fire = (sel >= 0) && memReady;
    eGnt = fire ? 3'(1 << sel) : 3'b000;
    check({tag, " R5 cmd valid"}, 64'(memCmdValid), 64'(sel >= 0));
    check({tag, " R4 grant"}, 64'(clientGnt), 64'(eGnt));
    if (expGnt >= 0) check({tag, " directed grant"}, 64'(clientGnt), 64'(expGnt));
    if (sel >= 0) begin
      eAddr = cont ? mAddr : clientAddr[sel*32 +: 32];
      eWe   = cont ? mWe : clientWe[sel];
      check({tag, " R11 cmd id"}, 64'(memCmdId), 64'(sel));
      check({tag, " R7 address"}, 64'(memCmdAddr), 64'(eAddr));
      check({tag, " R7 write flag"}, 64'(memCmdWe), 64'(eWe));
      check({tag, " R7 write data"}, 64'(memWdata), 64'(clientWdata[sel*32 +: 32]));
    end
    eRv = (memRvalid && memRid != 2'd3) ? 3'(1 << memRid) : 3'b000;
    check({tag, " R10 read valid"}, 64'(clientRvalid), 64'(eRv));
    if (memRvalid) check({tag, " R10 read data"}, 64'(clientRdata), 64'(memRdata));
    if (fire) begin
      if (cont) begin
        mCnt++;
        mAddr = mAddr + 32'd4;
        if (mCnt == 8) mLocked = 0;
      end else begin
        mLocked = 1;
        mOwner  = sel;
        mCnt    = 1;
        mAddr   = clientAddr[sel*32 +: 32] + 32'd4;
        mWe     = clientWe[sel];
      end
    end else if (!cont) begin
      mLocked = 0;
    end
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 0; prioOrder = DISC_FIRST; clientReq = '0; clientWe = '0;
    clientAddr = '0; clientWdata = '0; memReady = 1'b1;
    memRvalid = 1'b0; memRid = '0; memRdata = '0;
    repeat (4) @(negedge clk);
    rstN = 1;
    #1;
    // R1
    check("R1 reset grant", 64'(clientGnt), 64'd0);
    check("R1 reset valid", 64'(memCmdValid), 64'd0);
    @(negedge clk);

    // R2, R4, R9: disc-first order, all requesting
    clientAddr = {32'h3000_0000, 32'h2000_0000, 32'h1000_0000};
    clientWe = 3'b010;
    clientReq = 3'b111;
    step("R2 rank", 3'b010);
    for (int b = 1; b < 8; b++) begin
      if (b == 3) prioOrder = {2'd1, 2'd0, 2'd2}; // R4: client 2 now favoured
      clientWdata[63:32] = 32'hD000_0000 + 32'(b);
      step("R4 held", 3'b010);
    end
    step("R9 handover", 3'b100);

    // R6: stall mid-burst with others waiting
    memReady = 1'b0;
    for (int s = 0; s < 3; s++) begin
      step("R6 stall", 3'b000);
      check("R6 owner tag", 64'(memCmdId), 64'd2);
    end
    memReady = 1'b1;

    // R8: owner drops, same-cycle handover to client 1
    step("R8 pre", 3'b100);
    clientReq = 3'b011;
    prioOrder = {2'd0, 2'd1, 2'd2};
    step("R8 drop", 3'b010);

    // R3: illegal orders fall back to 0,1,2
    clientReq = 3'b000;
    step("R3 idle", 3'b000);
    prioOrder = 6'b000000;
    clientReq = 3'b110;
    step("R3 repeated", 3'b010);
    clientReq = 3'b000;
    step("R3 idle2", 3'b000);
    prioOrder = {2'd3, 2'd2, 2'd0};
    clientReq = 3'b111;
    step("R3 value3", 3'b001);
    clientReq = 3'b000;

    // R10: tag 3 routes nowhere, tag 2 to client 2
    memRvalid = 1'b1; memRid = 2'd3; memRdata = 32'hCAFE_0003;
    step("R10 tag3");
    check("R10 tag3 none", 64'(clientRvalid), 64'd0);
    memRid = 2'd2; memRdata = 32'hCAFE_0002;
    step("R10 tag2");
    memRvalid = 1'b0;

    // random phase
    void'($urandom(32'd1234));
    for (int cyc = 0; cyc < 6000; cyc++) begin
      for (int c = 0; c < 3; c++) begin
        if (clientReq[c]) begin
          if ($urandom % 20 == 0) clientReq[c] = 1'b0;
        end else if ($urandom % 4 == 0) begin
          clientReq[c] = 1'b1;
          clientAddr[c*32 +: 32] = $urandom & 32'hFFFF_FFFC;
          clientWe[c] = 1'($urandom % 2);
        end
        clientWdata[c*32 +: 32] = $urandom;
      end
      if (cyc % 150 == 0) begin
        case ($urandom % 4)
          0: prioOrder = 6'($urandom);
          1: prioOrder = DISC_FIRST;
          2: prioOrder = {2'd0, 2'd1, 2'd2};
          default: prioOrder = {2'd1, 2'd2, 2'd0};
        endcase
      end
      memReady  = ($urandom % 4) != 0;
      memRvalid = 1'($urandom % 2);
      memRid    = 2'($urandom);
      memRdata  = $urandom;
      step("random");
    end
    finishRun();
  end
endmodule